// File: doc/BRIEF.md
# Delay Line Preset Sequencer

This block brings a group of externally programmable delay lines to a known setting before photon timing calibration begins. The delay lines share one 10-bit code bus. Each line captures the bus on its own load strobe. A start request leaves idle, from either a local push button or a host command. The sequencer then walks through a fixed list of programming steps and raises a done flag, which releases the coarse delay search.

The list begins with every signal-path delay line, in ascending index order, each loaded with the minimum code. Next the pulse-stretcher line receives the code for a 35 ns pulse width. Last, the monostable line receives the code for a 3 ns pulse width. Each step drives the code word with all strobes low for `SETUP_CYC` cycles. It then raises exactly one strobe for `PULSE_CYC` cycles while the word stays unchanged. The codes, the number of path lines and both step lengths are parameters.

Top module: `dly_preset_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the sequencer goes idle: `dly_word` is 0, all strobes are low and `init_done` is low.
- R2: In idle, if either `btn_start` or `host_start` is high at a rising edge, the first step (path line 0, setup part) is presented from the next cycle on.
- R3: Steps run in this fixed order: path lines 0 up to `N_PATH-1`, then the stretcher line, then the monostable line.
- R4: The code word is `MIN_CODE` for every path step, `STRETCH_CODE` for the stretcher step and `MONO_CODE` for the monostable step.
- R5: Each step first holds its word for `SETUP_CYC` cycles with all strobes low. It then holds that word with only its own strobe high for `PULSE_CYC` cycles.
- R6: At most one strobe is high in any cycle. Strobe bits: `path_stb[i]` for path line i, plus `stretch_stb` and `mono_stb`.
- R7: In the cycle after the last monostable strobe cycle, `init_done` rises. It stays high until reset, with `dly_word` 0 and all strobes low.
- R8: Start inputs have no effect while a sequence is running or after it has completed.
- R9: A reset in the middle of a sequence abandons it. A later start runs the whole sequence again from path line 0.
- R10: In idle with no start request, `dly_word` stays 0 and no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_start | input | 1 | Start request from the local push button |
| host_start | input | 1 | Start request from the host |
| dly_word | output | 10 | Shared delay code bus |
| path_stb | output | N_PATH | Load strobes of the signal-path delay lines |
| stretch_stb | output | 1 | Load strobe of the stretcher delay line |
| mono_stb | output | 1 | Load strobe of the monostable delay line |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The hardest situations to reach are start requests that arrive while a sequence is already running or has finished, and a reset that cuts a sequence short. The stimulus queues a partial expected trace and fires a host start in the middle of it. It then lets the trace drain and drops reset at that point. After the sequence completes, it pulses both start inputs while `init_done` is held. At each of these points, the following cycles must match the undisturbed sequence or the idle state exactly.

// File: rtl/dlyseq_pkg.sv
// Shared types of the delay line preset sequencer.
// Assumes: nothing beyond the standard language.
package dlyseq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;
endpackage

// File: rtl/dlyseq_timer.sv
// Step timer: counts cycles inside the setup or strobe part of a step and
// flags the last cycle of that part.
// Assumes: SETUP_CYC and PULSE_CYC are at least 1; phase changes only on last_o.
module dlyseq_timer
    import dlyseq_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase_i,
    output logic   last_o
);
    localparam int MAXC  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim_m1;
    logic             run;

    // Pick the length of the current part of the step.
    always_comb begin
        run    = (phase_i == PH_SETUP) || (phase_i == PH_PULSE);
        lim_m1 = (phase_i == PH_SETUP) ? CNT_W'(SETUP_CYC - 1) : CNT_W'(PULSE_CYC - 1);
        last_o = run && (cnt == lim_m1);
    end

    // Advance the cycle count; restart it at each part boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last_o) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= lim_m1));
endmodule

// File: rtl/dlyseq_decode.sv
// Output decoder: turns the phase and step index into the code word and the
// one strobe that belongs to the step.
// Assumes: step_i is below N_PATH+2 whenever the phase is setup or pulse.
module dlyseq_decode
    import dlyseq_pkg::*;
#(
    parameter int          N_PATH       = 5,
    parameter int          WORD_W       = 10,
    parameter int          STEP_W       = 3,
    parameter [WORD_W-1:0] MIN_CODE     = '0,
    parameter [WORD_W-1:0] STRETCH_CODE = 10'd27,
    parameter [WORD_W-1:0] MONO_CODE    = 10'd9
) (
    input  phase_t            phase_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [WORD_W-1:0] word_o,
    output logic [N_PATH-1:0] path_stb_o,
    output logic              stretch_stb_o,
    output logic              mono_stb_o
);
    logic active;
    logic pulse;

    // Select the code word of the current step; zero outside a sequence.
    always_comb begin
        active = (phase_i == PH_SETUP) || (phase_i == PH_PULSE);
        pulse  = (phase_i == PH_PULSE);
        if (!active)                          word_o = '0;
        else if (step_i < STEP_W'(N_PATH))    word_o = MIN_CODE;
        else if (step_i == STEP_W'(N_PATH))   word_o = STRETCH_CODE;
        else                                  word_o = MONO_CODE;
        stretch_stb_o = pulse && (step_i == STEP_W'(N_PATH));
        mono_stb_o    = pulse && (step_i == STEP_W'(N_PATH + 1));
    end

    // One strobe per signal-path line, raised only in its own step.
    for (genvar g = 0; g < N_PATH; g++) begin : g_path
        assign path_stb_o[g] = pulse && (step_i == STEP_W'(g));
    end
endmodule

// File: rtl/dly_preset_seq.sv
// Delay line preset sequencer: on a start request, programs every signal-path
// delay line to the minimum code, then the stretcher line, then the monostable
// line, each as a setup part followed by a strobe part, and finally raises a
// sticky done flag.
// Assumes: synchronous active-low reset; SETUP_CYC >= 1 and PULSE_CYC >= 1.
module dly_preset_seq
    import dlyseq_pkg::*;
#(
    parameter int          N_PATH       = 5,
    parameter int          WORD_W       = 10,
    parameter int          SETUP_CYC    = 2,
    parameter int          PULSE_CYC    = 3,
    parameter [WORD_W-1:0] MIN_CODE     = '0,
    parameter [WORD_W-1:0] STRETCH_CODE = 10'd27,
    parameter [WORD_W-1:0] MONO_CODE    = 10'd9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_start,
    input  logic              host_start,
    output logic [WORD_W-1:0] dly_word,
    output logic [N_PATH-1:0] path_stb,
    output logic              stretch_stb,
    output logic              mono_stb,
    output logic              init_done
);
    localparam int N_STEP    = N_PATH + 2;
    localparam int STEP_W    = $clog2(N_STEP);
    localparam int LAST_STEP = N_STEP - 1;

    phase_t            phase;
    logic [STEP_W-1:0] step;
    logic              part_last;
    logic              start_req;

    assign start_req = btn_start || host_start;

    dlyseq_timer #(
        .SETUP_CYC(SETUP_CYC),
        .PULSE_CYC(PULSE_CYC)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .phase_i(phase),
        .last_o (part_last)
    );

    dlyseq_decode #(
        .N_PATH      (N_PATH),
        .WORD_W      (WORD_W),
        .STEP_W      (STEP_W),
        .MIN_CODE    (MIN_CODE),
        .STRETCH_CODE(STRETCH_CODE),
        .MONO_CODE   (MONO_CODE)
    ) i_decode (
        .phase_i      (phase),
        .step_i       (step),
        .word_o       (dly_word),
        .path_stb_o   (path_stb),
        .stretch_stb_o(stretch_stb),
        .mono_stb_o   (mono_stb)
    );

    // Sequence control: idle, per-step setup and strobe parts, sticky done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start_req) begin
                    phase <= PH_SETUP;
                    step  <= '0;
                end
                PH_SETUP: if (part_last) phase <= PH_PULSE;
                PH_PULSE: if (part_last) begin
                    if (step == STEP_W'(LAST_STEP)) phase <= PH_DONE;
                    else begin
                        phase <= PH_SETUP;
                        step  <= step + 1'b1;
                    end
                end
                PH_DONE: phase <= PH_DONE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Done flag follows the terminal phase.
    assign init_done = (phase == PH_DONE);

    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mono_stb, stretch_stb, path_stb}));

    // R5
    word_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|{mono_stb, stretch_stb, path_stb}) |-> $stable(dly_word));

    // R5
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{mono_stb, stretch_stb, path_stb}) |=> ($stable(dly_word) || !(|{mono_stb, stretch_stb, path_stb})));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && dly_word == '0));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !(|{mono_stb, stretch_stb, path_stb}));

    // R2
    start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && start_req) |=> (phase == PH_SETUP && step == '0));
endmodule

// File: tb/test_dly_preset_seq.sv
// Scoreboard bench: driver tasks queue the expected per-cycle outputs, the
// monitor pops and compares one entry at each falling clock edge.
module test_dly_preset_seq;
    localparam int          NP   = 5;
    localparam int          WW   = 10;
    localparam int          SC   = 2;
    localparam int          PC   = 3;
    localparam [WW-1:0]     MINC = 10'd0;
    localparam [WW-1:0]     STRC = 10'd27;
    localparam [WW-1:0]     MONC = 10'd9;
    localparam int          SW   = NP + 2;
    localparam int          TLEN = (NP + 2) * (SC + PC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          btn_start = 1'b0;
    logic          host_start = 1'b0;
    logic [WW-1:0] dly_word;
    logic [NP-1:0] path_stb;
    logic          stretch_stb;
    logic          mono_stb;
    logic          init_done;

    int vectors = 0;
    int fails   = 0;
    bit finished = 1'b0;

    logic [WW-1:0] q_word[$];
    logic [SW-1:0] q_stb[$];
    logic          q_done[$];
    string         q_tag[$];

    always #10 clk = ~clk;

    dly_preset_seq #(
        .N_PATH(NP), .WORD_W(WW), .SETUP_CYC(SC), .PULSE_CYC(PC),
        .MIN_CODE(MINC), .STRETCH_CODE(STRC), .MONO_CODE(MONC)
    ) i_dly_preset_seq (
        .clk(clk), .rst_n(rst_n), .btn_start(btn_start), .host_start(host_start),
        .dly_word(dly_word), .path_stb(path_stb), .stretch_stb(stretch_stb),
        .mono_stb(mono_stb), .init_done(init_done)
    );

    task automatic push(input logic [WW-1:0] w, input logic [SW-1:0] s,
                        input logic d, input string tag);
        q_word.push_back(w);
        q_stb.push_back(s);
        q_done.push_back(d);
        q_tag.push_back(tag);
    endtask

    // Queue the first n cycles of a complete sequence (R2 R3 R4 R5).
    task automatic push_trace(input int n);
        for (int i = 0; i < n && i < TLEN; i++) begin
            int            s;
            int            k;
            logic [WW-1:0] w;
            s = i / (SC + PC);
            k = i % (SC + PC);
            w = (s < NP) ? MINC : ((s == NP) ? STRC : MONC);
            if (i == 0)      push(w, '0, 1'b0, "R2");
            else if (k < SC) push(w, '0, 1'b0, "R4 R5 setup");
            else             push(w, SW'(1) << s, 1'b0, "R3 R5 strobe");
        end
    endtask

    task automatic drain();
        wait (q_word.size() == 0);
        @(negedge clk); #1;
    endtask

    // Monitor: compare outputs against the head of the queue.
    always @(negedge clk) begin
        if (q_word.size() > 0) begin
            logic [WW-1:0] ew;
            logic [SW-1:0] es;
            logic [SW-1:0] as;
            logic          ed;
            string         tg;
            ew = q_word.pop_front();
            es = q_stb.pop_front();
            ed = q_done.pop_front();
            tg = q_tag.pop_front();
            as = {mono_stb, stretch_stb, path_stb};
            vectors++;
            if (dly_word !== ew || as !== es || init_done !== ed) begin
                fails++;
                $display("FAIL %s: word=%0d stb=%b done=%b expected word=%0d stb=%b done=%b",
                         tg, dly_word, as, init_done, ew, es, ed);
            end
            // R6: at most one strobe
            vectors++;
            if ($countones(as) > 1) begin
                fails++;
                $display("FAIL R6: stb=%b expected at most one bit", as);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk); #1;
        for (int i = 0; i < 3; i++) push('0, '0, 1'b0, "R1");
        drain();
        rst_n = 1'b1;
        // R10: idle without a start request
        for (int i = 0; i < 4; i++) push('0, '0, 1'b0, "R10");
        drain();

        // Full sequence from the push button; host start mid-run ignored (R8)
        push_trace(TLEN);
        btn_start = 1'b1;
        @(posedge clk); #1;
        btn_start = 1'b0;
        repeat (7) @(posedge clk);
        #1 host_start = 1'b1;
        @(posedge clk); #1;
        host_start = 1'b0;
        wait (q_word.size() == 0);
        // R7: done rises after the last strobe cycle and holds
        for (int i = 0; i < 6; i++) push('0, '0, 1'b1, "R7");
        drain();
        // R8: starts ignored once done
        for (int i = 0; i < 4; i++) push('0, '0, 1'b1, "R8");
        btn_start = 1'b1;
        host_start = 1'b1;
        @(posedge clk); #1;
        btn_start = 1'b0;
        host_start = 1'b0;
        drain();

        // R9: reset mid-sequence, then restart from the host input
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) push('0, '0, 1'b0, "R1");
        drain();
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) push('0, '0, 1'b0, "R10");
        drain();
        push_trace(12);
        host_start = 1'b1;
        @(posedge clk); #1;
        host_start = 1'b0;
        wait (q_word.size() == 0);
        @(negedge clk); #1;
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) push('0, '0, 1'b0, "R9 reset");
        drain();
        rst_n = 1'b1;
        push_trace(TLEN);
        host_start = 1'b1;
        @(posedge clk); #1;
        host_start = 1'b0;
        wait (q_word.size() == 0);
        for (int i = 0; i < 3; i++) push('0, '0, 1'b1, "R9 R7");
        drain();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule